// File: doc/BRIEF.md
# Snooping MESI Cache Line Controller

This block keeps the coherence state of every line of a small direct-mapped, one-word-per-line cache attached to a shared snooping bus. Processor loads and stores that can be served locally complete in the cycle they are presented. Loads and stores that need the bus raise a bus request carrying a read, a read-for-ownership, an upgrade or a writeback command. They hold the processor ready low until the bus grants that transaction. In the grant cycle the bus returns fill data and the OR of the other caches' snoop-hit signals.

The block also watches the transactions that other caches place on the bus. For each one it looks up its own tag in the same cycle, reports a snoop hit, supplies its data when it holds the only dirty copy, and lowers its own line state. A parameter turns the controller into a plain three-state controller, in which a line is never installed as Exclusive. Arbitration, memory and the other caches sit outside the block.

Top module: `snoop_coh_cache`

## Requirements
- R1: After reset every line is Invalid, so any first processor load raises a bus request with command code 0 (read) for its own address, with processor ready low.
- R2: When a read command is granted, the load completes in that cycle with the bus fill data on the read data port. The line becomes Exclusive if the combined snoop-hit input is low and Shared if it is high.
- R3: With the three-state parameter set, a read fill always installs Shared, so a later store to that line raises an upgrade (code 2).
- R4: A store that misses raises read-for-ownership (code 1). A store to a Shared line raises upgrade (code 2). Either one completes in its grant cycle and leaves the line Modified with the store data.
- R5: A store to an Exclusive line, any access that hits a Modified line, and any load that hits an Exclusive or Shared line raise no bus request and complete in the cycle presented.
- R6: A snooped read (code 0) that matches a valid line reports a hit in the same cycle. A Modified match also raises the snoop writeback flag with the line data and leaves the line Shared. Exclusive becomes Shared, and Shared stays Shared.
- R7: A snooped read-for-ownership (code 1) or upgrade (code 2) that matches a valid line reports a hit and makes the line Invalid. A Modified match first supplies its data on the snoop writeback outputs.
- R8: A processor miss whose indexed line is Modified under another tag first raises a writeback (code 3) with the victim's address and data. Once that is granted the line is Invalid and the miss command follows.
- R9: Snoops are served while a request waits for grant. In a cycle with a snoop, processor ready stays low. A pending request is re-decided from the state the snoop leaves, so a pending upgrade whose line was invalidated becomes a read-for-ownership.
- R10: A snooped writeback (code 3), or a snoop whose tag does not match, reports no hit and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access valid, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: index in low bits, tag above |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with ready on a load |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address (victim address for writeback) |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Own transaction takes place this cycle |
| bus_shared | input | 1 | OR of other caches' snoop hits, valid with grant |
| bus_rdata | input | DATA_W | Fill data, valid with grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | This cache holds a valid copy of the snooped line |
| snp_wb | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Supplied dirty data |

## Verification
No output shows the line states directly. A wrong state is seen only the next time that line is touched. A processor access then shows the wrong bus command, an unexpected request or a missing one, or a wrong ready. A snoop then shows a wrong hit or writeback flag. Because every response is combinational on the stored state, the error shows in the very cycle of that next access. A reference model of the state per line, driven by a mix of random accesses, snoops, grants and shared responses over a small tag pool, compares every one of these outputs in every cycle. As a result, a wrong transition is seen at the next conflicting access rather than lost.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_RFO   = 2'd1,
    BC_UPGR  = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int SETS     = 4,
  parameter int TAG_W    = 10,
  parameter int DATA_W   = 32,
  parameter bit MSI_ONLY = 1'b0,
  localparam int IDX_W   = $clog2(SETS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        cpu_idx,
  output logic [TAG_W-1:0]        cpu_line_tag,
  output line_state_e             cpu_line_st,
  output logic [DATA_W-1:0]       cpu_line_data,
  input  logic [IDX_W-1:0]        snp_idx,
  output logic [TAG_W-1:0]        snp_line_tag,
  output line_state_e             snp_line_st,
  output logic [DATA_W-1:0]       snp_line_data,
  output line_state_e [SETS-1:0]  st_all,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  line_state_e             wr_st,
  input  logic                    wr_tag_en,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic                    wr_data_en,
  input  logic [DATA_W-1:0]       wr_data
);

  logic [TAG_W-1:0]  tag_arr  [SETS];
  logic [DATA_W-1:0] data_arr [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    logic        sel;
    line_state_e st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      st_d = st_q;
      if (sel) st_d = wr_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LS_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_tag_en)  tag_q  <= wr_tag;
      if (sel && wr_data_en) data_q <= wr_data;
    end

    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
    assign st_all[g]   = st_q;
  end

  assign cpu_line_tag  = tag_arr[cpu_idx];
  assign cpu_line_st   = st_all[cpu_idx];
  assign cpu_line_data = data_arr[cpu_idx];
  assign snp_line_tag  = tag_arr[snp_idx];
  assign snp_line_st   = st_all[snp_idx];
  assign snp_line_data = data_arr[snp_idx];

  if (MSI_ONLY) begin : g_msi_chk
    // R3
    msi_no_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_st != LS_EXC));
  end

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_state_e       line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              hit,
  output logic              wb,
  output logic [DATA_W-1:0] wb_data,
  output logic              upd_en,
  output line_state_e       upd_st
);

  logic match;

  always_comb begin
    match  = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
    hit    = 1'b0;
    wb     = 1'b0;
    upd_en = 1'b0;
    upd_st = line_st;
    unique case (snp_cmd)
      BC_READ: begin
        hit    = match;
        wb     = match && (line_st == LS_MOD);
        upd_en = match && (line_st != LS_SHR);
        upd_st = LS_SHR;
      end
      BC_RFO, BC_UPGR: begin
        hit    = match;
        wb     = match && (line_st == LS_MOD);
        upd_en = match;
        upd_st = LS_INV;
      end
      default: begin
        hit    = 1'b0;
        upd_en = 1'b0;
      end
    endcase
    wb_data = wb ? line_data : '0;
  end

endmodule

// File: rtl/coh_cpu_unit.sv
module coh_cpu_unit
  import coh_pkg::*;
#(
  parameter int TAG_W    = 10,
  parameter int DATA_W   = 32,
  parameter bit MSI_ONLY = 1'b0
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_state_e       line_st,
  input  logic [DATA_W-1:0] line_data,
  input  logic              hold,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              need_bus,
  output bus_cmd_e          cmd,
  output logic [DATA_W-1:0] wb_data,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              upd_en,
  output line_state_e       upd_st,
  output logic              upd_tag_en,
  output logic              upd_data_en,
  output logic [DATA_W-1:0] upd_data
);

  logic tag_hit;
  logic granted;

  always_comb begin
    tag_hit  = (line_st != LS_INV) && (line_tag == cpu_tag);
    need_bus = 1'b0;
    cmd      = BC_READ;
    if (cpu_req) begin
      if (!tag_hit && line_st == LS_MOD) begin
        need_bus = 1'b1;
        cmd      = BC_WBACK;
      end else if (!tag_hit) begin
        need_bus = 1'b1;
        cmd      = cpu_we ? BC_RFO : BC_READ;
      end else if (cpu_we && line_st == LS_SHR) begin
        need_bus = 1'b1;
        cmd      = BC_UPGR;
      end
    end
    wb_data = (need_bus && cmd == BC_WBACK) ? line_data : '0;
  end

  always_comb begin
    granted     = need_bus && bus_gnt;
    ready       = 1'b0;
    rdata       = line_data;
    upd_en      = 1'b0;
    upd_st      = line_st;
    upd_tag_en  = 1'b0;
    upd_data_en = 1'b0;
    upd_data    = cpu_wdata;
    if (cpu_req && !hold) begin
      if (!need_bus) begin
        ready = 1'b1;
        if (cpu_we) begin
          upd_en      = 1'b1;
          upd_st      = LS_MOD;
          upd_data_en = 1'b1;
        end
      end else if (granted) begin
        unique case (cmd)
          BC_WBACK: begin
            upd_en = 1'b1;
            upd_st = LS_INV;
          end
          BC_READ: begin
            ready       = 1'b1;
            rdata       = bus_rdata;
            upd_en      = 1'b1;
            upd_tag_en  = 1'b1;
            upd_data_en = 1'b1;
            upd_data    = bus_rdata;
            upd_st      = (MSI_ONLY || bus_shared) ? LS_SHR : LS_EXC;
          end
          BC_RFO: begin
            ready       = 1'b1;
            upd_en      = 1'b1;
            upd_tag_en  = 1'b1;
            upd_data_en = 1'b1;
            upd_st      = LS_MOD;
          end
          default: begin
            ready       = 1'b1;
            upd_en      = 1'b1;
            upd_data_en = 1'b1;
            upd_st      = LS_MOD;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/snoop_coh_cache.sv
module snoop_coh_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int SETS     = 4,
  parameter bit MSI_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_wb,
  output logic [DATA_W-1:0] snp_data
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0]       c_tag, s_tag;
  line_state_e            c_st, s_st;
  logic [DATA_W-1:0]      c_data, s_data;
  line_state_e [SETS-1:0] st_all;

  logic              wr_en, wr_tag_en, wr_data_en;
  logic [IDX_W-1:0]  wr_idx;
  line_state_e       wr_st;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  coh_line_store #(
    .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .MSI_ONLY(MSI_ONLY)
  ) u_store (
    .clk(clk), .rst_n(rst_sn),
    .cpu_idx(cpu_idx), .cpu_line_tag(c_tag), .cpu_line_st(c_st), .cpu_line_data(c_data),
    .snp_idx(snp_idx), .snp_line_tag(s_tag), .snp_line_st(s_st), .snp_line_data(s_data),
    .st_all(st_all),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
    .wr_tag_en(wr_tag_en), .wr_tag(wr_tag),
    .wr_data_en(wr_data_en), .wr_data(wr_data)
  );

  logic        s_upd_en;
  line_state_e s_upd_st;

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_tag),
    .line_tag(s_tag), .line_st(s_st), .line_data(s_data),
    .hit(snp_hit), .wb(snp_wb), .wb_data(snp_data),
    .upd_en(s_upd_en), .upd_st(s_upd_st)
  );

  bus_cmd_e          c_cmd;
  logic              c_upd_en, c_upd_tag_en, c_upd_data_en;
  line_state_e       c_upd_st;
  logic [DATA_W-1:0] c_upd_data;

  coh_cpu_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .MSI_ONLY(MSI_ONLY)) u_cpu (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_wdata(cpu_wdata),
    .line_tag(c_tag), .line_st(c_st), .line_data(c_data),
    .hold(snp_valid), .bus_gnt(bus_gnt), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .need_bus(bus_req), .cmd(c_cmd), .wb_data(bus_wdata),
    .ready(cpu_ready), .rdata(cpu_rdata),
    .upd_en(c_upd_en), .upd_st(c_upd_st), .upd_tag_en(c_upd_tag_en),
    .upd_data_en(c_upd_data_en), .upd_data(c_upd_data)
  );

  assign bus_cmd  = c_cmd;
  assign bus_addr = {(c_cmd == BC_WBACK) ? c_tag : cpu_tag, cpu_idx};

  // single write port: a snoop update wins, the processor side is held then
  always_comb begin
    wr_en      = c_upd_en;
    wr_idx     = cpu_idx;
    wr_st      = c_upd_st;
    wr_tag_en  = c_upd_tag_en;
    wr_tag     = cpu_tag;
    wr_data_en = c_upd_data_en;
    wr_data    = c_upd_data;
    if (snp_valid) begin
      wr_en      = s_upd_en;
      wr_idx     = snp_idx;
      wr_st      = s_upd_st;
      wr_tag_en  = 1'b0;
      wr_data_en = 1'b0;
    end
  end

  // R9
  snoop_holds_cpu_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    snp_valid |-> !cpu_ready);

  // R6
  wb_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    snp_wb |-> snp_hit);

  // R5
  local_done_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_ready && !bus_gnt) |-> !bus_req);

  // R7
  snoop_inval_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (snp_valid && snp_hit && (snp_cmd == 2'd1 || snp_cmd == 2'd2))
      |=> (st_all[$past(snp_idx)] == LS_INV));

  // R2
  fill_state_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_req && bus_gnt && !snp_valid && bus_cmd == 2'd0)
      |=> (st_all[$past(cpu_idx)] == LS_SHR || st_all[$past(cpu_idx)] == LS_EXC));

  // R4
  own_to_mod_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_req && bus_gnt && !snp_valid && (bus_cmd == 2'd1 || bus_cmd == 2'd2))
      |=> (st_all[$past(cpu_idx)] == LS_MOD));

  // R8
  victim_wb_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_req && bus_gnt && !snp_valid && bus_cmd == 2'd3)
      |=> (st_all[$past(cpu_idx)] == LS_INV));

endmodule

// File: tb/snoop_coh_cache_bench.sv
module snoop_coh_cache_bench;

  localparam int CLK_T  = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SETS   = 4;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int N_RAND = 4000;

  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
  localparam logic [1:0] CRD = 2'd0, CRFO = 2'd1, CUPG = 2'd2, CWB = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic bus_gnt = 0, bus_shared = 0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;

  logic cpu_ready, bus_req, snp_hit, snp_wb;
  logic [DATA_W-1:0] cpu_rdata, bus_wdata, snp_data;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;

  logic m_ready, m_req, m_hit, m_wb;
  logic [DATA_W-1:0] m_rdata, m_wdata, m_sdata;
  logic [1:0] m_cmd;
  logic [ADDR_W-1:0] m_addr;

  always #(CLK_T/2) clk = ~clk;

  snoop_coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .MSI_ONLY(1'b0))
  u_snoop_coh_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_wb(snp_wb), .snp_data(snp_data)
  );

  snoop_coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .MSI_ONLY(1'b1))
  u_snoop_coh_cache_msi (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(m_ready), .cpu_rdata(m_rdata),
    .bus_req(m_req), .bus_cmd(m_cmd), .bus_addr(m_addr), .bus_wdata(m_wdata),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_hit(m_hit), .snp_wb(m_wb), .snp_data(m_sdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [1:0]        ref_st  [SETS];
  logic [TAG_W-1:0]  ref_tag [SETS];
  logic [DATA_W-1:0] ref_dat [SETS];

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_req = 0; snp_valid = 0; bus_gnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < SETS; i++) ref_st[i] = SI;
  endtask

  function automatic string cmd_tag(input logic [1:0] c);
    case (c)
      CRD:  return "R2";
      CWB:  return "R8";
      default: return "R4";
    endcase
  endfunction

  // one random-phase cycle: inputs already driven, now at negedge
  task automatic step(input logic p_req, input logic p_we, input logic [ADDR_W-1:0] p_addr,
                      input logic [DATA_W-1:0] p_wd, output logic done_op);
    logic [IDX_W-1:0] idx, sidx;
    logic [TAG_W-1:0] tg, stg;
    logic hit, need, smatch, exp_rdy;
    logic [1:0] ecmd;
    #1;
    idx = p_addr[IDX_W-1:0];
    tg  = p_addr[ADDR_W-1:IDX_W];
    hit = (ref_st[idx] != SI) && (ref_tag[idx] == tg);
    need = 0; ecmd = CRD;
    if (p_req) begin
      if (!hit && ref_st[idx] == SM) begin need = 1; ecmd = CWB; end
      else if (!hit) begin need = 1; ecmd = p_we ? CRFO : CRD; end
      else if (p_we && ref_st[idx] == SS) begin need = 1; ecmd = CUPG; end
    end
    chk(need ? {cmd_tag(ecmd), " bus_req"} : "R5 bus_req", 64'(bus_req), 64'(need));
    if (need) begin
      chk({cmd_tag(ecmd), " bus_cmd"}, 64'(bus_cmd), 64'(ecmd));
      if (ecmd == CWB) begin
        chk("R8 victim addr", 64'(bus_addr), 64'({ref_tag[idx], idx}));
        chk("R8 victim data", 64'(bus_wdata), 64'(ref_dat[idx]));
      end else begin
        chk({cmd_tag(ecmd), " bus_addr"}, 64'(bus_addr), 64'(p_addr));
      end
    end
    exp_rdy = p_req && !snp_valid && (!need || (bus_gnt && ecmd != CWB));
    chk(snp_valid ? "R9 ready during snoop" : (need ? {cmd_tag(ecmd), " ready"} : "R5 ready"),
        64'(cpu_ready), 64'(exp_rdy));
    if (exp_rdy && !p_we)
      chk(need ? "R2 fill data" : "R5 hit data", 64'(cpu_rdata),
          64'(need ? bus_rdata : ref_dat[idx]));
    smatch = 0;
    sidx = snp_addr[IDX_W-1:0];
    stg  = snp_addr[ADDR_W-1:IDX_W];
    if (snp_valid) begin
      smatch = (ref_st[sidx] != SI) && (ref_tag[sidx] == stg) && (snp_cmd != CWB);
      chk((snp_cmd == CWB) ? "R10 snoop hit" : (snp_cmd == CRD ? "R6 snoop hit" : "R7 snoop hit"),
          64'(snp_hit), 64'(smatch));
      chk(snp_cmd == CRD ? "R6 snoop wb" : "R7 snoop wb", 64'(snp_wb),
          64'(smatch && ref_st[sidx] == SM));
      if (smatch && ref_st[sidx] == SM)
        chk(snp_cmd == CRD ? "R6 snoop data" : "R7 snoop data", 64'(snp_data),
            64'(ref_dat[sidx]));
    end else begin
      chk("R10 idle snoop hit", 64'(snp_hit), 64'd0);
    end
    // model update, takes effect at the coming edge
    if (snp_valid) begin
      if (smatch) ref_st[sidx] = (snp_cmd == CRD) ? SS : SI;
    end else if (p_req) begin
      if (!need) begin
        if (p_we) begin ref_st[idx] = SM; ref_dat[idx] = p_wd; end
      end else if (bus_gnt) begin
        case (ecmd)
          CWB:  ref_st[idx] = SI;
          CRD:  begin ref_st[idx] = bus_shared ? SS : SE; ref_tag[idx] = tg; ref_dat[idx] = bus_rdata; end
          CRFO: begin ref_st[idx] = SM; ref_tag[idx] = tg; ref_dat[idx] = p_wd; end
          default: begin ref_st[idx] = SM; ref_dat[idx] = p_wd; end
        endcase
      end
    end
    done_op = exp_rdy;
  endtask

  initial begin
    logic p_req, p_we, fin;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_wd;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: first load after reset needs a bus read, both variants
    cpu_req = 1; cpu_we = 0; cpu_addr = 12'h0a5; bus_gnt = 0;
    #1;
    chk("R1 bus_req", 64'(bus_req), 64'd1);
    chk("R1 bus_cmd", 64'(bus_cmd), 64'(CRD));
    chk("R1 bus_addr", 64'(bus_addr), 64'h0a5);
    chk("R1 ready low", 64'(cpu_ready), 64'd0);
    chk("R1 msi bus_req", 64'(m_req), 64'd1);
    @(negedge clk);
    // R2/R3: grant with no sharer
    bus_gnt = 1; bus_shared = 0; bus_rdata = 32'hcafe_0001;
    #1;
    chk("R2 fill ready", 64'(cpu_ready), 64'd1);
    chk("R2 fill data", 64'(cpu_rdata), 64'hcafe_0001);
    chk("R3 msi fill ready", 64'(m_ready), 64'd1);
    @(negedge clk);
    // store: silent in four-state mode, upgrade in three-state mode
    bus_gnt = 0; cpu_we = 1; cpu_wdata = 32'h1234_5678;
    #1;
    chk("R5 silent E store bus_req", 64'(bus_req), 64'd0);
    chk("R5 silent E store ready", 64'(cpu_ready), 64'd1);
    chk("R3 msi store bus_req", 64'(m_req), 64'd1);
    chk("R3 msi store bus_cmd", 64'(m_cmd), 64'(CUPG));
    chk("R3 msi store ready", 64'(m_ready), 64'd0);
    @(negedge clk);
    bus_gnt = 1;
    #1;
    chk("R3 msi upgrade done", 64'(m_ready), 64'd1);
    @(negedge clk);
    // R6: snooped read of the Modified line supplies data
    cpu_req = 0; bus_gnt = 0; snp_valid = 1; snp_cmd = CRD; snp_addr = 12'h0a5;
    #1;
    chk("R6 snoop M hit", 64'(snp_hit), 64'd1);
    chk("R6 snoop M wb", 64'(snp_wb), 64'd1);
    chk("R6 snoop M data", 64'(snp_data), 64'h1234_5678);
    @(negedge clk);
    snp_valid = 0;

    // R9 race: pending upgrade is invalidated by a snoop, becomes RFO
    cpu_req = 1; cpu_we = 1; cpu_addr = 12'h0a5; cpu_wdata = 32'h0bad_f00d;
    #1;
    chk("R9 pending upgrade cmd", 64'(bus_cmd), 64'(CUPG));
    @(negedge clk);
    snp_valid = 1; snp_cmd = CRFO; snp_addr = 12'h0a5;
    #1;
    chk("R9 ready during snoop", 64'(cpu_ready), 64'd0);
    chk("R7 snoop S hit", 64'(snp_hit), 64'd1);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R9 upgrade became RFO", 64'(bus_cmd), 64'(CRFO));
    @(negedge clk);

    do_reset();
    p_req = 0; p_we = 0; p_addr = '0; p_wd = '0;
    for (int n = 0; n < N_RAND; n++) begin
      if (!p_req && ($urandom % 4) != 0) begin
        p_req  = 1;
        p_we   = $urandom % 2;
        p_addr = {TAG_W'($urandom % 3), IDX_W'($urandom % SETS)};
        p_wd   = $urandom;
      end
      cpu_req = p_req; cpu_we = p_we; cpu_addr = p_addr; cpu_wdata = p_wd;
      snp_valid = (($urandom % 4) == 0);
      snp_cmd   = 2'($urandom % 4);
      snp_addr  = {TAG_W'($urandom % 3), IDX_W'($urandom % SETS)};
      bus_gnt   = !snp_valid && (($urandom % 2) == 1);
      bus_shared = $urandom % 2;
      bus_rdata  = $urandom;
      step(p_req, p_we, p_addr, p_wd, fin);
      if (fin) p_req = 0;
      @(negedge clk);
    end
    cpu_req = 0; snp_valid = 0; bus_gnt = 0;
    @(negedge clk);
    finish_run();
  end

endmodule